// File: doc/BRIEF.md
# Graded Interrupt Request Prioritizer

This block gathers sixteen interrupt request lines from the modules of a crate. Each line carries a fixed grade. Line `i` has grade `i+1`. Grade 1 is the most urgent and grade 16 the least urgent. The block presents only the most urgent qualifying request to the host. It does this with one registered interrupt line and a 5-bit grade number, and the grade number reads 0 whenever nothing is presented.

The host starts service of the presented grade with a one-cycle acknowledge pulse. It finishes the most urgent grade in service with a one-cycle end-of-service pulse. The block holds the set of grades in service, which acts as a nesting stack. When nesting is enabled, only a grade strictly more urgent than the most urgent one in service is presented. When that nested service ends, the interrupted grade becomes current again. When nesting is disabled, nothing is presented while any grade is in service.

The sampled request vector is always readable, so a host can poll the lines instead of taking interrupts. All pins are plain level or pulse controls. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `irq_grade_arbiter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `irq_o` = 0, `grade_o` = 0, `cur_grade_o` = 0 and `raw_o` = 0, whatever `req_i` holds.
- R2: `raw_o` equals the value `req_i` had at the previous rising clock edge, regardless of mode or service state.
- R3: With no grade in service, `irq_o` and `grade_o` update one edge after `req_i`. Bit `i` of `req_i` maps to grade `i+1`. The lowest-numbered active grade is shown, and `irq_o` = 0 with `grade_o` = 0 when no request is active.
- R4: `cur_grade_o` shows the most urgent grade in service, or 0 when none. An `ack_i` pulse while `irq_o` = 1 adds `grade_o` to the in-service set, so `cur_grade_o` shows that grade after the edge.
- R5: With `nest_en_i` = 1 and a grade in service, a request is presented only if its grade number is strictly below `cur_grade_o`. Requests of equal or higher grade number are withheld, with `irq_o` = 0 and `grade_o` = 0.
- R6: An `eos_i` pulse removes the most urgent grade in service, and the next most urgent one (or 0) becomes `cur_grade_o`.
- R7: With `nest_en_i` = 0, `irq_o` stays 0 while any grade is in service. The pending request is presented on the edge at which the last service ends.
- R8: `ack_i` while `irq_o` = 0 is ignored. `eos_i` while nothing is in service is ignored. Both leave `cur_grade_o` unchanged.
- R9: After an acknowledged presentation, the same grade is not presented on the next cycle.
- R10: When `ack_i` (with `irq_o` = 1) and `eos_i` arrive in the same cycle, the most urgent grade previously in service is removed and the acknowledged grade is added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 16 | Request lines, bit i has grade i+1 |
| nest_en_i | input | 1 | 1 allows preemption by more urgent grades |
| ack_i | input | 1 | Host acknowledge pulse, starts service of grade_o |
| eos_i | input | 1 | Host end-of-service pulse, ends the most urgent service |
| irq_o | output | 1 | Registered interrupt line |
| grade_o | output | 5 | Presented grade, 0 when none |
| cur_grade_o | output | 5 | Most urgent grade in service, 0 when none |
| raw_o | output | 16 | Sampled request vector for polling |

## Verification
The bench targets four cases.

- Equal-grade withholding. A design that compares with "less or equal" re-presents a grade already in service.
- The cycle right after an acknowledge. A presentation register fed from the old in-service set shows the acknowledged grade twice, which invites a double acknowledge.
- Acknowledge and end-of-service in the same cycle. A design that drops one of the two, or pops the newly pushed grade, leaves the wrong `cur_grade_o`.
- Stray pulses and non-nested mode. A design that accepts an acknowledge with no interrupt raised corrupts the in-service set. A design that ignores the mode input raises interrupts during service.

// File: rtl/irq_grade_pkg.sv
package irq_grade_pkg;

  localparam int unsigned IRQ_SRC_DEFAULT = 16;

  function automatic int unsigned grade_width(input int unsigned n_src);
    return $clog2(n_src + 1);
  endfunction

  typedef enum logic [1:0] {
    SVC_HOLD = 2'd0,
    SVC_PUSH = 2'd1,
    SVC_POP  = 2'd2,
    SVC_SWAP = 2'd3
  } svc_op_e;

endpackage

// File: rtl/irq_first_set.sv
// Lowest-index set bit, returned as a 1-based grade (0 when vector is empty).
module irq_first_set #(
  parameter int unsigned N  = 16,
  parameter int unsigned GW = 5
) (
  input  logic [N-1:0]  vec_i,
  output logic [GW-1:0] grade_o
);

  logic [N-1:0] seen;
  logic [N-1:0] hit;

  assign seen[0] = 1'b0;

  genvar gi;
  generate
    for (gi = 1; gi < N; gi++) begin : g_chain
      assign seen[gi] = seen[gi-1] | vec_i[gi-1];
    end
    for (gi = 0; gi < N; gi++) begin : g_hit
      assign hit[gi] = vec_i[gi] & ~seen[gi];
    end
  endgenerate

  always_comb begin
    grade_o = '0;
    for (int i = 0; i < N; i++) begin
      if (hit[i]) grade_o = grade_o | GW'(i + 1);
    end
  end

endmodule

// File: rtl/irq_grade_decode.sv
// 1-based grade number to one-hot vector (all zero for grade 0).
module irq_grade_decode #(
  parameter int unsigned N  = 16,
  parameter int unsigned GW = 5
) (
  input  logic [GW-1:0] grade_i,
  output logic [N-1:0]  onehot_o
);

  always_comb begin
    for (int i = 0; i < N; i++) begin
      onehot_o[i] = (grade_i == GW'(i + 1));
    end
  end

endmodule

// File: rtl/irq_svc_tracker.sv
// Holds the set of grades in service; the most urgent bit is the top of the
// nesting stack.
module irq_svc_tracker
  import irq_grade_pkg::*;
#(
  parameter int unsigned N  = 16,
  parameter int unsigned GW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [GW-1:0] push_grade_i,
  input  logic          pop_i,
  output logic [N-1:0]  mask_d_o,
  output logic [GW-1:0] cur_grade_o
);

  logic [N-1:0]  mask_q;
  logic [N-1:0]  mask_d;
  logic [N-1:0]  push_oh;
  logic [N-1:0]  top_oh;
  logic [GW-1:0] top_grade;
  logic          busy;
  svc_op_e       op;

  irq_first_set #(.N(N), .GW(GW)) u_top (
    .vec_i   (mask_q),
    .grade_o (top_grade)
  );

  irq_grade_decode #(.N(N), .GW(GW)) u_top_dec (
    .grade_i  (top_grade),
    .onehot_o (top_oh)
  );

  irq_grade_decode #(.N(N), .GW(GW)) u_push_dec (
    .grade_i  (push_grade_i),
    .onehot_o (push_oh)
  );

  assign busy = |mask_q;

  always_comb begin
    unique case ({push_i, pop_i & busy})
      2'b10:   op = SVC_PUSH;
      2'b01:   op = SVC_POP;
      2'b11:   op = SVC_SWAP;
      default: op = SVC_HOLD;
    endcase
  end

  always_comb begin
    unique case (op)
      SVC_PUSH: mask_d = mask_q | push_oh;
      SVC_POP:  mask_d = mask_q & ~top_oh;
      SVC_SWAP: mask_d = (mask_q & ~top_oh) | push_oh;
      default:  mask_d = mask_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  assign mask_d_o    = mask_d;
  assign cur_grade_o = top_grade;

endmodule

// File: rtl/irq_present_reg.sv
// Qualifies the most urgent request against the next in-service set and
// registers the interrupt line, grade number and polled request vector.
module irq_present_reg #(
  parameter int unsigned N  = 16,
  parameter int unsigned GW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  input  logic          nest_en_i,
  input  logic [N-1:0]  mask_d_i,
  output logic          irq_o,
  output logic [GW-1:0] grade_o,
  output logic [N-1:0]  raw_o
);

  logic [GW-1:0] win_grade;
  logic [GW-1:0] svc_grade;
  logic          win_any;
  logic          svc_any;
  logic          qualify;
  logic          irq_q;
  logic [GW-1:0] grade_q;
  logic [N-1:0]  raw_q;

  irq_first_set #(.N(N), .GW(GW)) u_win (
    .vec_i   (req_i),
    .grade_o (win_grade)
  );

  irq_first_set #(.N(N), .GW(GW)) u_svc (
    .vec_i   (mask_d_i),
    .grade_o (svc_grade)
  );

  assign win_any = (win_grade != '0);
  assign svc_any = (svc_grade != '0);

  always_comb begin
    if (!win_any)      qualify = 1'b0;
    else if (!svc_any) qualify = 1'b1;
    else               qualify = nest_en_i && (win_grade < svc_grade);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      grade_q <= '0;
      raw_q   <= '0;
    end else begin
      irq_q   <= qualify;
      grade_q <= qualify ? win_grade : '0;
      raw_q   <= req_i;
    end
  end

  assign irq_o   = irq_q;
  assign grade_o = grade_q;
  assign raw_o   = raw_q;

endmodule

// File: rtl/irq_grade_arbiter.sv
module irq_grade_arbiter
  import irq_grade_pkg::*;
#(
  parameter int unsigned N_SRC = IRQ_SRC_DEFAULT
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N_SRC-1:0]               req_i,
  input  logic                           nest_en_i,
  input  logic                           ack_i,
  input  logic                           eos_i,
  output logic                           irq_o,
  output logic [grade_width(N_SRC)-1:0]  grade_o,
  output logic [grade_width(N_SRC)-1:0]  cur_grade_o,
  output logic [N_SRC-1:0]               raw_o
);

  localparam int unsigned GRADE_W = grade_width(N_SRC);

  logic [N_SRC-1:0] mask_next;
  logic             take;

  assign take = ack_i & irq_o;

  irq_svc_tracker #(.N(N_SRC), .GW(GRADE_W)) u_tracker (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_i       (take),
    .push_grade_i (grade_o),
    .pop_i        (eos_i),
    .mask_d_o     (mask_next),
    .cur_grade_o  (cur_grade_o)
  );

  irq_present_reg #(.N(N_SRC), .GW(GRADE_W)) u_present (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .nest_en_i (nest_en_i),
    .mask_d_i  (mask_next),
    .irq_o     (irq_o),
    .grade_o   (grade_o),
    .raw_o     (raw_o)
  );

endmodule

// File: rtl/irq_grade_arbiter_chk.sv
module irq_grade_arbiter_chk
  import irq_grade_pkg::*;
#(
  parameter int unsigned N_SRC = IRQ_SRC_DEFAULT
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [N_SRC-1:0]               req_i,
  input logic                           nest_en_i,
  input logic                           ack_i,
  input logic                           eos_i,
  input logic                           irq_o,
  input logic [grade_width(N_SRC)-1:0]  grade_o,
  input logic [grade_width(N_SRC)-1:0]  cur_grade_o,
  input logic [N_SRC-1:0]               raw_o
);

  // R2
  raw_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> raw_o == $past(req_i));

  // R3
  idle_grade_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> grade_o == '0);

  // R4
  ack_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o && !eos_i) |=> cur_grade_o == $past(grade_o));

  // R5
  nest_strict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && cur_grade_o != '0) |-> grade_o < cur_grade_o);

  // R6
  eos_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eos_i && !ack_i && cur_grade_o != '0) |=>
      (cur_grade_o == '0 || cur_grade_o > $past(cur_grade_o)));

  // R7
  flat_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_grade_o != '0 && !$past(nest_en_i)) |-> !irq_o);

  // R8
  stray_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!ack_i || !irq_o) && (!eos_i || cur_grade_o == '0)) |=> $stable(cur_grade_o));

  // R9
  no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o) |=> !(irq_o && grade_o == $past(grade_o)));

endmodule

bind irq_grade_arbiter irq_grade_arbiter_chk #(.N_SRC(N_SRC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_i       (req_i),
  .nest_en_i   (nest_en_i),
  .ack_i       (ack_i),
  .eos_i       (eos_i),
  .irq_o       (irq_o),
  .grade_o     (grade_o),
  .cur_grade_o (cur_grade_o),
  .raw_o       (raw_o)
);

// File: tb/irq_grade_arbiter_bench.sv
`timescale 1ns/1ps
module irq_grade_arbiter_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] req = '0;
  logic        nest = 1'b1;
  logic        ack = 1'b0;
  logic        eos = 1'b0;
  logic        irq;
  logic [4:0]  grade;
  logic [4:0]  cur;
  logic [15:0] raw;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [15:0] m_mask = '0;
  logic        m_irq  = 1'b0;
  logic [4:0]  m_grade = '0;
  logic [15:0] m_raw  = '0;

  always #2 clk = ~clk;

  irq_grade_arbiter u_irq_grade_arbiter (
    .clk(clk), .rst_n(rst_n), .req_i(req), .nest_en_i(nest),
    .ack_i(ack), .eos_i(eos), .irq_o(irq), .grade_o(grade),
    .cur_grade_o(cur), .raw_o(raw)
  );

  function automatic logic [4:0] low_grade(input logic [15:0] v);
    for (int i = 0; i < 16; i++) if (v[i]) return 5'(i + 1);
    return 5'd0;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Reference update for one clock edge, from the requirements.
  task automatic model(input logic [15:0] r, input logic n, input logic a, input logic e);
    logic [15:0] m;
    logic [4:0]  w, t;
    bit q;
    m = m_mask;
    if (e && m != 0) m = m & ~(16'd1 << (low_grade(m) - 1));
    if (a && m_irq) m = m | (16'd1 << (m_grade - 1));
    m_mask = m;
    w = low_grade(r);
    t = low_grade(m);
    q = (w != 0) && ((m == 0) || (n && w < t));
    m_irq = q;
    m_grade = q ? w : 5'd0;
    m_raw = r;
  endtask

  task automatic step(input logic [15:0] r, input logic n, input logic a,
                      input logic e, input string tag);
    string ti;
    @(negedge clk);
    req = r; nest = n; ack = a; eos = e;
    @(posedge clk);
    #1;
    model(r, n, a, e);
    if (tag != "") ti = tag;
    else if (m_mask == 0) ti = "R3";
    else if (n) ti = "R5";
    else ti = "R7";
    check(irq == m_irq, ti, "irq_o", irq, m_irq);
    check(grade == m_grade, ti, "grade_o", grade, m_grade);
    check(cur == low_grade(m_mask), (tag != "") ? tag : "R4", "cur_grade_o", cur, low_grade(m_mask));
    check(raw == m_raw, "R2", "raw_o", raw, m_raw);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1624));
    req = 16'hFFFF;
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs quiet during reset
    check(irq == 0 && grade == 0, "R1", "irq/grade in reset", {irq, grade}, 0);
    check(raw == 0 && cur == 0, "R1", "raw/cur in reset", raw, 0);
    @(negedge clk);
    req = 16'h0000;
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check(irq == 0 && grade == 0 && cur == 0, "R1", "first cycle out", {irq, grade, cur}, 0);
    check(raw == 0, "R1", "first cycle raw", raw, 0);

    step(16'h0000, 1, 0, 0, "R3");
    step(16'h0010, 1, 0, 0, "R3");
    check(grade == 5'd5, "R3", "bit4 -> grade", grade, 5);
    step(16'h8011, 1, 0, 0, "R3");
    check(grade == 5'd1, "R3", "lowest index wins", grade, 1);
    step(16'h0020, 1, 0, 0, "R3");
    step(16'h0020, 1, 1, 0, "R9");
    check(cur == 5'd6 && irq == 0, "R9", "acked grade not re-shown", {irq, cur}, 6);
    step(16'h0060, 1, 0, 0, "R5");
    check(irq == 0 && grade == 0, "R5", "equal/lower withheld", {irq, grade}, 0);
    step(16'h0024, 1, 0, 0, "R5");
    check(grade == 5'd3, "R5", "more urgent preempts", grade, 3);
    step(16'h0024, 1, 1, 0, "R4");
    check(cur == 5'd3, "R4", "nested push", cur, 3);
    step(16'h0000, 1, 0, 1, "R6");
    check(cur == 5'd6, "R6", "interrupted resumes", cur, 6);
    step(16'h0000, 1, 0, 1, "R6");
    check(cur == 5'd0, "R6", "last pop", cur, 0);
    // R8: stray pulses
    step(16'h0000, 1, 1, 0, "R8");
    step(16'h0000, 1, 0, 1, "R8");
    check(cur == 5'd0, "R8", "stray ack/eos ignored", cur, 0);
    // R7: nesting off
    step(16'h0020, 0, 0, 0, "R7");
    step(16'h0020, 0, 1, 0, "R7");
    step(16'h0001, 0, 0, 0, "R7");
    check(irq == 0, "R7", "no nest while busy", irq, 0);
    step(16'h0001, 0, 0, 1, "R7");
    check(irq == 1 && grade == 5'd1, "R7", "presented at end", grade, 1);
    step(16'h0001, 0, 1, 0, "R7");
    step(16'h0000, 0, 0, 1, "R7");
    // R10: simultaneous ack and end
    step(16'h0020, 1, 0, 0, "R10");
    step(16'h0020, 1, 1, 0, "R10");
    step(16'h0002, 1, 0, 0, "R10");
    step(16'h0002, 1, 1, 1, "R10");
    check(cur == 5'd2, "R10", "swap result", cur, 2);
    step(16'h0000, 1, 0, 1, "R10");
    check(cur == 5'd0, "R10", "swap left one entry", cur, 0);

    for (int k = 0; k < 3000; k++) begin
      logic [15:0] r;
      logic n;
      r = ($urandom % 4 == 0) ? 16'h0 : 16'($urandom & $urandom & $urandom);
      n = ((k / 400) % 3) != 2;
      step(r, n, ($urandom % 3) == 0, ($urandom % 5) == 0, "");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule